// File: doc/BRIEF.md
# Paged Register Window to 32-bit Internal Bus Bridge

This block sits behind a management register port whose registers are 16 bits wide and addressed by a 5-bit register number. It gives that port access to a 32-bit internal address space. A page register, always reachable at register 0x1F, chooses which page the other 31 register numbers land in. When the extension page (page 4) is selected, registers 0x10 to 0x18 form a bridge window. All other accesses are forwarded untouched to a standard-register port.

Through the window, software loads a write address and write data, or a read address, as pairs of 16-bit halves. The access to the low half launches one 32-bit transfer on an internal request/acknowledge bus. A write to the low write-data register commits a write. A write to the low read-address register starts a read, and the returned word is captured so that both read-data halves belong to the same word. When the mode register requests auto-increment, the write address advances by 4 after every committed write. This lets a bulk load stream consecutive words with only data-half writes.

Top module: `mgmt_wide_bridge`

## Requirements
- R1: Register 0x1F holds the page number. A write stores all 16 bits and a read returns them. The page resets to 0. Register 0x1F is local on every page.
- R2: An access is handled by the bridge only when it targets 0x1F, or when the page equals 4 and the register is in 0x10..0x18. Every other access drives `std_wr`/`std_rd` with `std_addr`/`std_wdata` equal to the request, and `mgr_rdata` then equals `std_rdata`. Such an access never starts a bus request and never changes a bridge register.
- R3: Register 0x10 is the mode register. Bit 15 set selects auto-increment, and bit 15 clear keeps the address fixed. A read returns bit 15 in position 15 and zeros elsewhere.
- R4: Registers 0x11/0x12 hold the write address high/low halves, 0x13 holds the write data high half, and 0x15/0x16 hold the read address high/low halves. Each reads back the last value stored. Register 0x14 reads back the last low data half written.
- R5: A write to 0x14 while idle raises `bus_req` with `bus_we`=1 in the next cycle. `bus_addr` is {0x11,0x12} and `bus_wdata` is {0x13, the value just written}.
- R6: After a committed write in auto-increment mode, the write address read from 0x11/0x12 is 4 larger. In fixed mode it is unchanged.
- R7: A write to 0x16 while idle raises `bus_req` with `bus_we`=0 and `bus_addr` = {0x15, the value just written}. The word on `bus_rdata` at the acknowledge is captured: 0x17 returns its bits 31:16 and 0x18 its bits 15:0.
- R8: `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay stable until `bus_ack` is seen. `bus_req` drops in the cycle after the acknowledge. `busy` is high exactly while a request is outstanding.
- R9: A write to 0x14 or 0x16 while `busy` is high stores the register value but launches no transfer and does not advance the write address.
- R10: After reset, `busy` and `bus_req` are low and every bridge window register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgr_wr | input | 1 | Register write strobe, one cycle per write |
| mgr_rd | input | 1 | Register read strobe |
| mgr_addr | input | 5 | Register number |
| mgr_wdata | input | 16 | Register write value |
| mgr_rdata | output | 16 | Register read value, combinational from `mgr_addr` |
| std_wr | output | 1 | Forwarded write strobe for standard registers |
| std_rd | output | 1 | Forwarded read strobe for standard registers |
| std_addr | output | 5 | Forwarded register number |
| std_wdata | output | 16 | Forwarded write value |
| std_rdata | input | 16 | Read value from standard registers |
| busy | output | 1 | An internal transfer is outstanding |
| bus_req | output | 1 | Internal bus request |
| bus_we | output | 1 | Internal bus write (1) or read (0) |
| bus_addr | output | 32 | Internal bus byte address |
| bus_wdata | output | 32 | Internal bus write word |
| bus_rdata | input | 32 | Internal bus read word |
| bus_ack | input | 1 | Internal bus acknowledge, one cycle |

## Verification
The bench builds the block with its default parameters: extension page 4, window base 0x10 and an address step of 4. It attaches a bus responder whose acknowledge latency it sweeps from 0 to 2 cycles, and raises to 6 for the busy case. For every latency it streams words in auto-increment mode and in fixed mode, then reads each address back through the read window. Expected addresses and data patterns are computed arithmetically. The long latency lets a second commit land while a transfer is outstanding. The page sweep over 0, 3 and 4 checks that window register numbers go to the standard port, and that this leaves the bridge registers and the bus untouched.

// File: rtl/mgmt_bridge_pkg.sv
package mgmt_bridge_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int RNUM_W = 5;

    // decoded target of a management access
    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_PAGE,
        SEL_MODE,
        SEL_WA_HI,
        SEL_WA_LO,
        SEL_WD_HI,
        SEL_WD_LO,
        SEL_RA_HI,
        SEL_RA_LO,
        SEL_RD_HI,
        SEL_RD_LO
    } win_sel_e;

    // window register file state
    typedef struct packed {
        logic [HALF_W-1:0] page;
        logic              incr;
        logic [HALF_W-1:0] wa_hi;
        logic [HALF_W-1:0] wa_lo;
        logic [HALF_W-1:0] wd_hi;
        logic [HALF_W-1:0] wd_lo;
        logic [HALF_W-1:0] ra_hi;
        logic [HALF_W-1:0] ra_lo;
    } win_regs_t;

    // transfer engine state
    typedef struct packed {
        logic              req;
        logic              we;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] rdata;
    } xfer_t;

endpackage

// File: rtl/bridge_window_decode.sv
module bridge_window_decode
    import mgmt_bridge_pkg::*;
#(
    parameter logic [HALF_W-1:0] EXT_PAGE = 16'd4,
    parameter logic [RNUM_W-1:0] PAGE_REG = 5'h1F,
    parameter logic [RNUM_W-1:0] WIN_BASE = 5'h10
) (
    input  logic [RNUM_W-1:0] addr,
    input  logic [HALF_W-1:0] page,
    output win_sel_e          sel
);
    localparam int WIN_SPAN = 9;

    // targets in window order, offset 0 first
    win_sel_e win_map [WIN_SPAN];
    assign win_map[0] = SEL_MODE;
    assign win_map[1] = SEL_WA_HI;
    assign win_map[2] = SEL_WA_LO;
    assign win_map[3] = SEL_WD_HI;
    assign win_map[4] = SEL_WD_LO;
    assign win_map[5] = SEL_RA_HI;
    assign win_map[6] = SEL_RA_LO;
    assign win_map[7] = SEL_RD_HI;
    assign win_map[8] = SEL_RD_LO;

    logic [RNUM_W-1:0] offs;
    logic [WIN_SPAN-1:0] hit;

    assign offs = addr - WIN_BASE;

    genvar gi;
    generate
        for (gi = 0; gi < WIN_SPAN; gi++) begin : g_hit
            assign hit[gi] = (page == EXT_PAGE) && (offs == RNUM_W'(gi))
                             && (addr >= WIN_BASE);
        end
    endgenerate

    always_comb begin
        sel = SEL_NONE;
        if (addr == PAGE_REG) begin
            sel = SEL_PAGE;
        end else begin
            for (int i = 0; i < WIN_SPAN; i++) begin
                if (hit[i]) sel = win_map[i];
            end
        end
    end

endmodule

// File: rtl/bridge_window_regs.sv
module bridge_window_regs
    import mgmt_bridge_pkg::*;
#(
    parameter int ADDR_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  win_sel_e          sel,
    input  logic [HALF_W-1:0] wdata,
    input  logic              busy,
    input  logic [WORD_W-1:0] cap_word,
    output logic [HALF_W-1:0] page,
    output logic              start_wr,
    output logic              start_rd,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] rd_addr,
    output logic [HALF_W-1:0] rdata
);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(ADDR_STEP);

    win_regs_t r_q, r_d;

    assign page     = r_q.page;
    assign wr_addr  = {r_q.wa_hi, r_q.wa_lo};
    assign wr_word  = {r_q.wd_hi, wdata};
    assign rd_addr  = {r_q.ra_hi, wdata};
    assign start_wr = wr && (sel == SEL_WD_LO) && !busy;
    assign start_rd = wr && (sel == SEL_RA_LO) && !busy;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            case (sel)
                SEL_PAGE:  r_d.page  = wdata;
                SEL_MODE:  r_d.incr  = wdata[HALF_W-1];
                SEL_WA_HI: r_d.wa_hi = wdata;
                SEL_WA_LO: r_d.wa_lo = wdata;
                SEL_WD_HI: r_d.wd_hi = wdata;
                SEL_WD_LO: r_d.wd_lo = wdata;
                SEL_RA_HI: r_d.ra_hi = wdata;
                SEL_RA_LO: r_d.ra_lo = wdata;
                default:   ;
            endcase
        end
        if (start_wr && r_q.incr) begin
            {r_d.wa_hi, r_d.wa_lo} = wr_addr + STEP;
        end
    end

    always_comb begin
        case (sel)
            SEL_PAGE:  rdata = r_q.page;
            SEL_MODE:  rdata = {r_q.incr, {(HALF_W-1){1'b0}}};
            SEL_WA_HI: rdata = r_q.wa_hi;
            SEL_WA_LO: rdata = r_q.wa_lo;
            SEL_WD_HI: rdata = r_q.wd_hi;
            SEL_WD_LO: rdata = r_q.wd_lo;
            SEL_RA_HI: rdata = r_q.ra_hi;
            SEL_RA_LO: rdata = r_q.ra_lo;
            SEL_RD_HI: rdata = cap_word[WORD_W-1:HALF_W];
            SEL_RD_LO: rdata = cap_word[HALF_W-1:0];
            default:   rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_STEP_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && r_q.incr) |=> (wr_addr == $past(wr_addr) + STEP)); // R6
    AST_FIXED_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && !r_q.incr && !(wr && (sel == SEL_MODE))) |=> $stable(wr_addr)); // R6
    AST_BUSY_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr && (sel == SEL_WD_LO)) |=> $stable(wr_addr)); // R9

endmodule

// File: rtl/bridge_xfer.sv
module bridge_xfer
    import mgmt_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              start_rd,
    input  logic [WORD_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [WORD_W-1:0] rd_addr,
    input  logic              bus_ack,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [WORD_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] cap_word,
    output logic              busy
);
    xfer_t x_q, x_d;

    always_comb begin
        x_d = x_q;
        if (x_q.req) begin
            if (bus_ack) begin
                x_d.req = 1'b0;
                if (!x_q.we) x_d.rdata = bus_rdata;
            end
        end else if (start_wr) begin
            x_d.req   = 1'b1;
            x_d.we    = 1'b1;
            x_d.addr  = wr_addr;
            x_d.wdata = wr_word;
        end else if (start_rd) begin
            x_d.req  = 1'b1;
            x_d.we   = 1'b0;
            x_d.addr = rd_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) x_q <= '0;
        else        x_q <= x_d;
    end

    assign bus_req   = x_q.req;
    assign bus_we    = x_q.we;
    assign bus_addr  = x_q.addr;
    assign bus_wdata = x_q.wdata;
    assign cap_word  = x_q.rdata;
    assign busy      = x_q.req;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                   && $stable(bus_wdata))); // R8
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> !bus_req); // R8
    AST_CAPTURE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_ack && !bus_we) |=> $stable(cap_word)); // R7

endmodule

// File: rtl/mgmt_wide_bridge.sv
module mgmt_wide_bridge
    import mgmt_bridge_pkg::*;
#(
    parameter logic [15:0] EXT_PAGE  = 16'd4,
    parameter logic [4:0]  PAGE_REG  = 5'h1F,
    parameter logic [4:0]  WIN_BASE  = 5'h10,
    parameter int          ADDR_STEP = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mgr_wr,
    input  logic        mgr_rd,
    input  logic [4:0]  mgr_addr,
    input  logic [15:0] mgr_wdata,
    output logic [15:0] mgr_rdata,
    output logic        std_wr,
    output logic        std_rd,
    output logic [4:0]  std_addr,
    output logic [15:0] std_wdata,
    input  logic [15:0] std_rdata,
    output logic        busy,
    output logic        bus_req,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic [31:0] bus_rdata,
    input  logic        bus_ack
);
    win_sel_e          sel;
    logic [HALF_W-1:0] page;
    logic [HALF_W-1:0] local_rdata;
    logic              is_local;
    logic              start_wr, start_rd;
    logic [WORD_W-1:0] wr_addr, wr_word, rd_addr, cap_word;

    bridge_window_decode #(
        .EXT_PAGE (EXT_PAGE),
        .PAGE_REG (PAGE_REG),
        .WIN_BASE (WIN_BASE)
    ) i_decode (
        .addr (mgr_addr),
        .page (page),
        .sel  (sel)
    );

    bridge_window_regs #(
        .ADDR_STEP (ADDR_STEP)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (mgr_wr),
        .sel      (sel),
        .wdata    (mgr_wdata),
        .busy     (busy),
        .cap_word (cap_word),
        .page     (page),
        .start_wr (start_wr),
        .start_rd (start_rd),
        .wr_addr  (wr_addr),
        .wr_word  (wr_word),
        .rd_addr  (rd_addr),
        .rdata    (local_rdata)
    );

    bridge_xfer i_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (start_wr),
        .start_rd  (start_rd),
        .wr_addr   (wr_addr),
        .wr_word   (wr_word),
        .rd_addr   (rd_addr),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cap_word  (cap_word),
        .busy      (busy)
    );

    assign is_local  = (sel != SEL_NONE);
    assign std_wr    = mgr_wr && !is_local;
    assign std_rd    = mgr_rd && !is_local;
    assign std_addr  = mgr_addr;
    assign std_wdata = mgr_wdata;
    assign mgr_rdata = is_local ? local_rdata : std_rdata;

    AST_STD_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (std_wr || std_rd) |=> !$rose(bus_req)); // R2
    AST_STD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(std_wr && start_wr)); // R2

endmodule

// File: tb/test_mgmt_wide_bridge.sv
module test_mgmt_wide_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mgr_wr = 1'b0, mgr_rd = 1'b0;
    logic [4:0]  mgr_addr = '0;
    logic [15:0] mgr_wdata = '0;
    logic [15:0] mgr_rdata;
    logic        std_wr, std_rd;
    logic [4:0]  std_addr;
    logic [15:0] std_wdata, std_rdata;
    logic        busy, bus_req, bus_we, bus_ack;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;

    always #2.5 clk = ~clk;

    assign std_rdata = 16'hC000 | {11'd0, std_addr};

    mgmt_wide_bridge i_mgmt_wide_bridge (.*);

    // bus responder with programmable acknowledge latency
    logic [31:0] mem [64];
    int          lat = 0;
    int          cnt = 0;
    int          ntrans = 0;
    logic        last_we;
    logic [31:0] last_addr, last_wdata;

    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
            cnt       <= 0;
        end else if (bus_ack) begin
            bus_ack <= 1'b0;
        end else if (bus_req) begin
            if (cnt == lat) begin
                bus_ack    <= 1'b1;
                cnt        <= 0;
                ntrans     <= ntrans + 1;
                last_we    <= bus_we;
                last_addr  <= bus_addr;
                last_wdata <= bus_wdata;
                if (bus_we) mem[bus_addr[7:2]] <= bus_wdata;
                else        bus_rdata <= mem[bus_addr[7:2]];
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    int   n_tests = 0;
    int   n_fail = 0;
    logic seen_std;
    logic [4:0] seen_std_addr;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        mgr_addr = a; mgr_wdata = d; mgr_wr = 1'b1;
        #1 seen_std = std_wr; seen_std_addr = std_addr;
        @(posedge clk);
        #1 mgr_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        mgr_addr = a; mgr_rd = 1'b1;
        #1 d = mgr_rdata; seen_std = std_rd; seen_std_addr = std_addr;
        @(posedge clk);
        #1 mgr_rd = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    function automatic logic [31:0] pat(input int i, input int l, input int m);
        return 32'hA500_0000 ^ (l << 20) ^ (m << 16) ^ (i * 32'h0001_0203);
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v, h, lo;
        logic [31:0] base, a;
        int          t0;
        for (int k = 0; k < 64; k++) mem[k] = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state
        check("R10 busy", {31'd0, busy}, 32'd0);
        check("R10 bus_req", {31'd0, bus_req}, 32'd0);
        rd_reg(5'h1F, v); check("R1 page reset", {16'd0, v}, 32'd0);
        wr_reg(5'h1F, 16'd4);
        rd_reg(5'h1F, v); check("R1 page readback", {16'd0, v}, 32'd4);
        for (int r = 16; r <= 24; r++) begin
            rd_reg(5'(r), v);
            check($sformatf("R10 reg %0h reset", r), {16'd0, v}, 32'd0);
        end

        // R3 mode register readback
        wr_reg(5'h10, 16'hFFFF); rd_reg(5'h10, v);
        check("R3 mode incr read", {16'd0, v}, 32'h8000);
        wr_reg(5'h10, 16'h7FFF); rd_reg(5'h10, v);
        check("R3 mode fixed read", {16'd0, v}, 32'h0);

        // sweep latency and mode: stream writes, then read each back
        for (int l = 0; l <= 2; l++) begin
            lat = l;
            for (int m = 0; m <= 1; m++) begin
                int nw;
                nw = (m == 1) ? 4 : 2;
                base = 32'h0012_0000 + 32'((l * 2 + m) * 16);
                wr_reg(5'h10, (m == 1) ? 16'h8000 : 16'h0000);
                wr_reg(5'h11, base[31:16]);
                wr_reg(5'h12, base[15:0]);
                rd_reg(5'h11, v); check("R4 wa_hi", {16'd0, v}, {16'd0, base[31:16]});
                rd_reg(5'h12, v); check("R4 wa_lo", {16'd0, v}, {16'd0, base[15:0]});
                for (int i = 0; i < nw; i++) begin
                    a = pat(i, l, m);
                    t0 = ntrans;
                    wr_reg(5'h13, a[31:16]);
                    wr_reg(5'h14, a[15:0]);
                    check("R8 busy after commit", {31'd0, busy}, 32'd1);
                    check("R5 bus_we", {31'd0, bus_we}, 32'd1);
                    wait_idle();
                    check("R8 busy cleared", {31'd0, busy}, 32'd0);
                    check("R5 one transfer", 32'(ntrans - t0), 32'd1);
                    check("R5/R6 bus address", last_addr,
                          (m == 1) ? base + 32'(4 * i) : base);
                    check("R5 bus wdata", last_wdata, a);
                end
                rd_reg(5'h13, v); check("R4 wd_hi", {16'd0, v}, {16'd0, a[31:16]});
                rd_reg(5'h14, v); check("R4 wd_lo", {16'd0, v}, {16'd0, a[15:0]});
                rd_reg(5'h12, v);
                check("R6 final write address", {16'd0, v},
                      {16'd0, base[15:0] + ((m == 1) ? 16'(4 * nw) : 16'd0)});
                // R7 read back through the read window
                for (int i = 0; i < nw; i++) begin
                    logic [31:0] ra;
                    ra = (m == 1) ? base + 32'(4 * i) : base;
                    wr_reg(5'h15, ra[31:16]);
                    wr_reg(5'h16, ra[15:0]);
                    check("R7 read request", {30'd0, bus_req, bus_we}, 32'b10);
                    check("R7 read address", bus_addr, ra);
                    wait_idle();
                    rd_reg(5'h17, h); rd_reg(5'h18, lo);
                    check("R7 read word", {h, lo},
                          (m == 1) ? pat(i, l, m) : pat(nw - 1, l, m));
                end
                rd_reg(5'h15, v); check("R4 ra_hi", {16'd0, v}, {16'd0, base[31:16]});
            end
        end

        // R9 commit while busy is ignored
        lat = 6;
        base = 32'h0012_00C0;
        wr_reg(5'h10, 16'h8000);
        wr_reg(5'h11, base[31:16]);
        wr_reg(5'h12, base[15:0]);
        wr_reg(5'h13, 16'h1357);
        t0 = ntrans;
        wr_reg(5'h14, 16'h2468);
        check("R8 request pending", {31'd0, bus_req}, 32'd1);
        wr_reg(5'h14, 16'h9999);
        check("R8 address held", bus_addr, base);
        wr_reg(5'h16, 16'h0040);
        check("R9 no read launch", {31'd0, bus_we}, 32'd1);
        wait_idle();
        check("R9 single transfer", 32'(ntrans - t0), 32'd1);
        check("R9 first data kept", last_wdata, 32'h1357_2468);
        rd_reg(5'h12, v);
        check("R9 one increment", {16'd0, v}, {16'd0, base[15:0] + 16'd4});
        rd_reg(5'h14, v); check("R9 value stored", {16'd0, v}, 32'h9999);
        lat = 0;

        // R2 routing on other pages
        for (int p = 0; p <= 4; p++) begin
            if (p != 0 && p != 3 && p != 4) continue;
            wr_reg(5'h1F, 16'(p));
            rd_reg(5'h1F, v); check("R1 page value", {16'd0, v}, 32'(p));
            for (int r = 0; r < 31; r++) begin
                logic win;
                win = (p == 4) && (r >= 16) && (r <= 24);
                rd_reg(5'(r), v);
                check($sformatf("R2 std_rd p%0d r%0h", p, r), {31'd0, seen_std}, {31'd0, !win});
                if (!win) check("R2 std readback", {16'd0, v}, 32'hC000 | 32'(r));
            end
        end
        wr_reg(5'h1F, 16'd0);
        t0 = ntrans;
        wr_reg(5'h12, 16'hBEEF);
        check("R2 std_wr", {26'd0, seen_std, seen_std_addr}, {26'd0, 1'b1, 5'h12});
        wr_reg(5'h14, 16'h5555);
        check("R2 std_wr commit reg", {31'd0, seen_std}, 32'd1);
        repeat (4) @(negedge clk);
        check("R2 no bus access", 32'(ntrans - t0), 32'd0);
        wr_reg(5'h1F, 16'd4);
        rd_reg(5'h12, v);
        check("R2 bridge reg untouched", {16'd0, v}, {16'd0, base[15:0] + 16'd4});
        rd_reg(5'h14, v);
        check("R2 data reg untouched", {16'd0, v}, 32'h9999);

        summary();
        $finish;
    end

endmodule